// File: doc/BRIEF.md
# Serial Receive and Transmit Status Flag Controller

This block holds the status flags of a UART-style serial port and turns them into gated interrupt requests. The receive path, the transmit path and the bus decoder drive it with one-cycle event strobes and levels. It keeps the last accepted received byte in a holding register. It maintains five flags: receive-full, line-idle, overrun, noise and transmit-complete. The shifters, baud generation, oversampling and address decoding sit outside the block.

The receive flags clear in two steps. A status-register read records which flags were set at that moment. A later data-register read clears only the recorded flags and then empties the record, so a flag that sets between the two reads survives. Idle detection is driven by a small state machine with the states `IDL_WAIT_CHAR`, `IDL_ARMED` and `IDL_FLAGGED`:
- `IDL_WAIT_CHAR` goes to `IDL_ARMED` when a character is accepted.
- `IDL_ARMED` goes to `IDL_FLAGGED` when the run of ones reaches its threshold.
- `IDL_FLAGGED` goes back to `IDL_WAIT_CHAR` when the idle flag is cleared. It goes to `IDL_ARMED` instead if a character is accepted in the same cycle.
- Any state goes to `IDL_WAIT_CHAR` while the receiver is disabled.

Transmit-complete comes from a second state machine with the states `TX_EMPTY`, `TX_WAIT_START` and `TX_SHIFTING`:
- `TX_EMPTY` goes to `TX_WAIT_START` on a queue strobe.
- `TX_WAIT_START` goes to `TX_SHIFTING` when the transmitter reports busy.
- `TX_SHIFTING` goes to `TX_WAIT_START` when busy ends and a further load is pending. It goes to `TX_EMPTY` when busy ends and nothing is pending.

Top module: `sci_status_flags`

## Requirements
- R1: After reset, `flag_tc` is 1. `flag_rxf`, `flag_idle`, `flag_or`, `flag_nf` and all three interrupt outputs are 0, apart from `irq_tx` when `ie_tc` is 1.
- R2: A `rx_char_done` strobe that arrives while `flag_rxf` is 0 loads `rx_char_data` into `rx_data`. It also sets `flag_rxf` one cycle later.
- R3: A receive flag clears only when a `stat_rd` taken while the flag was set is followed later by a `data_rd`. A `data_rd` with no earlier `stat_rd` leaves all flags unchanged.
- R4: A `rx_char_done` that arrives while `flag_rxf` is 1, and is not being cleared in that cycle, sets `flag_or` and leaves `rx_data` unchanged.
- R5: A `data_rd` leaves set any flag that was 0 at the last `stat_rd`. After the `data_rd`, the record of flags is empty, so a second `data_rd` clears nothing.
- R6: A `rx_char_done` with `rx_char_noise` high sets `flag_nf`. The status-then-data read sequence clears it.
- R7: Once armed, `flag_idle` sets on the `rx_bit_tick` that completes a run of 10 consecutive ones when `long_frame`=0, or 11 when `long_frame`=1. A tick with `rx_line`=0 restarts the count.
- R8: `flag_idle` cannot set until a character has been accepted since `rx_en` rose, and again after each idle clear.
- R9: `flag_tc` drops in the cycle after `tx_load`. It stays 0 through the start latency and while `tx_busy` is high, and returns to 1 once busy ends with no load pending.
- R10: The interrupt outputs are gated as follows. `irq_rx` = (`flag_rxf` & `ie_rxf`) | (`flag_idle` & `ie_idle`). `irq_err` = (`flag_or` & `ie_or`) | (`flag_nf` & `ie_nf`). `irq_tx` = `flag_tc` & `ie_tc`.
- R11: A set event wins over a clearing `data_rd` in the same cycle. If a character completes while the read is clearing `flag_rxf`, the character loads, `flag_rxf` stays 1 and `flag_or` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled |
| long_frame | input | 1 | Idle threshold select (0: 10 ones, 1: 11 ones) |
| rx_bit_tick | input | 1 | One strobe per received bit time |
| rx_line | input | 1 | Sampled receive line value at the tick |
| rx_char_done | input | 1 | Received character complete |
| rx_char_data | input | DATA_W | Completed character |
| rx_char_noise | input | 1 | Noise seen on the completed character |
| tx_load | input | 1 | Data, preamble or break queued |
| tx_busy | input | 1 | Transmit shifter active |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| ie_rxf | input | 1 | Receive-full interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| ie_or | input | 1 | Overrun interrupt enable |
| ie_nf | input | 1 | Noise interrupt enable |
| ie_tc | input | 1 | Transmit-complete interrupt enable |
| rx_data | output | DATA_W | Data holding register |
| flag_tc | output | 1 | Transmit complete |
| flag_rxf | output | 1 | Receive full |
| flag_idle | output | 1 | Line idle |
| flag_or | output | 1 | Overrun |
| flag_nf | output | 1 | Noise |
| irq_rx | output | 1 | Receiver interrupt request |
| irq_err | output | 1 | Error interrupt request |
| irq_tx | output | 1 | Transmitter interrupt request |

## Verification
Two functions can fall in the same cycle: a clearing data read and a set event. The most sensitive pair is a clearing `data_rd` and a new `rx_char_done`. The bench provokes this in three ways:
- It first records `flag_rxf` with a status read. It then pulses the data read and a character strobe together, and expects `flag_rxf` still 1, the new byte in `rx_data` and no overrun.
- It completes a character between the status read and the data read. It then judges that the overrun set after the status read survives the data read.
- It sweeps the idle threshold over both frame lengths and run lengths around it.

// File: rtl/sci_flag_pkg.sv
package sci_flag_pkg;

    typedef struct packed {
        logic rxf;
        logic idle;
        logic ovr;
        logic nf;
    } rx_flag_vec_t;

    typedef enum logic [1:0] {
        IDL_WAIT_CHAR = 2'd0,
        IDL_ARMED     = 2'd1,
        IDL_FLAGGED   = 2'd2
    } idle_state_t;

    typedef enum logic [1:0] {
        TX_EMPTY      = 2'd0,
        TX_WAIT_START = 2'd1,
        TX_SHIFTING   = 2'd2
    } tx_state_t;

endpackage

// File: rtl/sci_rx_flags.sv
module sci_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              clr_rxf,
    input  logic              clr_or,
    input  logic              clr_nf,
    output logic              char_accept,
    output logic [DATA_W-1:0] hold_data,
    output logic              flag_rxf,
    output logic              flag_or,
    output logic              flag_nf
);

    logic ovr_evt;

    always_comb begin
        char_accept = char_done && (!flag_rxf || clr_rxf);
        ovr_evt     = char_done && flag_rxf && !clr_rxf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            flag_rxf  <= 1'b0;
            flag_or   <= 1'b0;
            flag_nf   <= 1'b0;
        end else begin
            if (char_accept) begin
                hold_data <= char_data;
                flag_rxf  <= 1'b1;
            end else if (clr_rxf) begin
                flag_rxf  <= 1'b0;
            end

            if (ovr_evt)     flag_or <= 1'b1;
            else if (clr_or) flag_or <= 1'b0;

            if (char_done && char_noise) flag_nf <= 1'b1;
            else if (clr_nf)             flag_nf <= 1'b0;
        end
    end

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_accept |=> flag_rxf && (hold_data == $past(char_data)));

    // R4
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> flag_or && $stable(hold_data));

    // R3
    rxf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rxf && !clr_rxf |=> flag_rxf);

endmodule

// File: rtl/sci_idle_fsm.sv
module sci_idle_fsm
    import sci_flag_pkg::*;
#(
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic long_frame,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic char_accept,
    input  logic clr_idle,
    output logic flag_idle
);

    localparam int CNT_W = $clog2(IDLE_LONG + 1);
    localparam logic [CNT_W:0] THR_S = IDLE_SHORT[CNT_W:0];
    localparam logic [CNT_W:0] THR_L = IDLE_LONG[CNT_W:0];

    idle_state_t      state_q, state_d;
    logic [CNT_W-1:0] ones_q;
    logic [CNT_W:0]   ones_inc;
    logic [CNT_W:0]   thr;
    logic             hit;

    always_comb begin
        thr      = long_frame ? THR_L : THR_S;
        ones_inc = {1'b0, ones_q} + 1'b1;
        hit      = bit_tick && rx_line && (ones_inc >= thr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= '0;
        end else if (!rx_en || char_accept) begin
            ones_q <= '0;
        end else if (bit_tick) begin
            if (!rx_line)        ones_q <= '0;
            else if (ones_inc < thr) ones_q <= ones_inc[CNT_W-1:0];
        end
    end

    always_comb begin
        state_d = state_q;
        if (!rx_en) begin
            state_d = IDL_WAIT_CHAR;
        end else begin
            unique case (state_q)
                IDL_WAIT_CHAR: if (char_accept) state_d = IDL_ARMED;
                IDL_ARMED:     if (!char_accept && hit) state_d = IDL_FLAGGED;
                IDL_FLAGGED:   if (clr_idle)
                                   state_d = char_accept ? IDL_ARMED : IDL_WAIT_CHAR;
                default:       state_d = IDL_WAIT_CHAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDL_WAIT_CHAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_idle = (state_q == IDL_FLAGGED);
    end

    // R8
    idle_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_idle) |-> $past(state_q) == IDL_ARMED);

    // R8
    disabled_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !flag_idle);

endmodule

// File: rtl/sci_tx_done_fsm.sv
module sci_tx_done_fsm
    import sci_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load,
    input  logic tx_busy,
    output logic flag_tc
);

    tx_state_t state_q, state_d;
    logic      more_q, more_d;

    always_comb begin
        state_d = state_q;
        more_d  = more_q;
        unique case (state_q)
            TX_EMPTY: begin
                more_d = 1'b0;
                if (tx_load) state_d = TX_WAIT_START;
            end
            TX_WAIT_START: begin
                more_d = 1'b0;
                if (tx_busy) state_d = TX_SHIFTING;
            end
            TX_SHIFTING: begin
                if (tx_load) more_d = 1'b1;
                if (!tx_busy) begin
                    state_d = (more_q || tx_load) ? TX_WAIT_START : TX_EMPTY;
                    more_d  = 1'b0;
                end
            end
            default: begin
                state_d = TX_EMPTY;
                more_d  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_EMPTY;
            more_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            more_q  <= more_d;
        end
    end

    always_comb begin
        flag_tc = (state_q == TX_EMPTY);
    end

    // R9
    tc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !flag_tc);

    // R9
    tc_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !flag_tc || $past(!tx_busy));

endmodule

// File: rtl/sci_status_flags.sv
module sci_status_flags
    import sci_flag_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IDLE_SHORT = 10,
    parameter int IDLE_LONG  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              long_frame,
    input  logic              rx_bit_tick,
    input  logic              rx_line,
    input  logic              rx_char_done,
    input  logic [DATA_W-1:0] rx_char_data,
    input  logic              rx_char_noise,
    input  logic              tx_load,
    input  logic              tx_busy,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              ie_rxf,
    input  logic              ie_idle,
    input  logic              ie_or,
    input  logic              ie_nf,
    input  logic              ie_tc,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_tc,
    output logic              flag_rxf,
    output logic              flag_idle,
    output logic              flag_or,
    output logic              flag_nf,
    output logic              irq_rx,
    output logic              irq_err,
    output logic              irq_tx
);

    rx_flag_vec_t seen_q;
    rx_flag_vec_t cur;
    rx_flag_vec_t clr;
    logic         char_accept;

    always_comb begin
        cur = '{rxf: flag_rxf, idle: flag_idle, ovr: flag_or, nf: flag_nf};
        clr = data_rd ? seen_q : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_q <= '0;
        else if (stat_rd) seen_q <= cur;
        else if (data_rd) seen_q <= '0;
    end

    sci_rx_flags #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .char_done   (rx_char_done),
        .char_data   (rx_char_data),
        .char_noise  (rx_char_noise),
        .clr_rxf     (clr.rxf),
        .clr_or      (clr.ovr),
        .clr_nf      (clr.nf),
        .char_accept (char_accept),
        .hold_data   (rx_data),
        .flag_rxf    (flag_rxf),
        .flag_or     (flag_or),
        .flag_nf     (flag_nf)
    );

    sci_idle_fsm #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .long_frame  (long_frame),
        .bit_tick    (rx_bit_tick),
        .rx_line     (rx_line),
        .char_accept (char_accept),
        .clr_idle    (clr.idle),
        .flag_idle   (flag_idle)
    );

    sci_tx_done_fsm u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_load (tx_load),
        .tx_busy (tx_busy),
        .flag_tc (flag_tc)
    );

    always_comb begin
        irq_rx  = (flag_rxf & ie_rxf) | (flag_idle & ie_idle);
        irq_err = (flag_or & ie_or) | (flag_nf & ie_nf);
        irq_tx  = flag_tc & ie_tc;
    end

    // R5
    seen_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !stat_rd |=> seen_q == '0);

    // R3
    no_unseen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_or && !(data_rd && seen_q.ovr) |=> flag_or);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_done && data_rd && seen_q.rxf |=> flag_rxf && !$rose(flag_or));

endmodule

// File: tb/sci_status_flags_bench.sv
module sci_status_flags_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, long_frame = 1'b0, rx_bit_tick = 1'b0, rx_line = 1'b1;
    logic       rx_char_done = 1'b0, rx_char_noise = 1'b0;
    logic [7:0] rx_char_data = 8'h00;
    logic       tx_load = 1'b0, tx_busy = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
    logic       ie_rxf = 1'b0, ie_idle = 1'b0, ie_or = 1'b0, ie_nf = 1'b0, ie_tc = 1'b0;
    logic [7:0] rx_data;
    logic       flag_tc, flag_rxf, flag_idle, flag_or, flag_nf, irq_rx, irq_err, irq_tx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sci_status_flags u_sci_status_flags (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .long_frame(long_frame),
        .rx_bit_tick(rx_bit_tick), .rx_line(rx_line), .rx_char_done(rx_char_done),
        .rx_char_data(rx_char_data), .rx_char_noise(rx_char_noise),
        .tx_load(tx_load), .tx_busy(tx_busy), .stat_rd(stat_rd), .data_rd(data_rd),
        .ie_rxf(ie_rxf), .ie_idle(ie_idle), .ie_or(ie_or), .ie_nf(ie_nf), .ie_tc(ie_tc),
        .rx_data(rx_data), .flag_tc(flag_tc), .flag_rxf(flag_rxf), .flag_idle(flag_idle),
        .flag_or(flag_or), .flag_nf(flag_nf), .irq_rx(irq_rx), .irq_err(irq_err),
        .irq_tx(irq_tx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_char(input logic [7:0] d, input logic noisy);
        rx_char_done = 1'b1; rx_char_data = d; rx_char_noise = noisy;
        step();
        rx_char_done = 1'b0; rx_char_noise = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic rd_data();
        data_rd = 1'b1; step(); data_rd = 1'b0;
    endtask

    task automatic tick(input logic b);
        rx_bit_tick = 1'b1; rx_line = b; step(); rx_bit_tick = 1'b0; rx_line = 1'b1;
    endtask

    task automatic clear_all();
        rd_stat(); rd_data();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        chk("R1 tc", flag_tc, 1);
        chk("R1 rxf", flag_rxf, 0);
        chk("R1 idle", flag_idle, 0);
        chk("R1 or", flag_or, 0);
        chk("R1 nf", flag_nf, 0);
        chk("R1 irqs", {irq_rx, irq_err, irq_tx}, 0);
        rst_n = 1'b1; rx_en = 1'b1;
        step();

        // R2
        send_char(8'hA5, 1'b0);
        chk("R2 rxf set", flag_rxf, 1);
        chk("R2 data", rx_data, 8'hA5);
        // R3: data read without status read
        rd_data();
        chk("R3 no clear without stat", flag_rxf, 1);
        rd_stat();
        chk("R3 stat alone no clear", flag_rxf, 1);
        rd_data();
        chk("R3 clear after sequence", flag_rxf, 0);

        // R4 overrun sweep
        for (int i = 0; i < 8; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 37 + 3); b = ~a;
            send_char(a, 1'b0);
            send_char(b, 1'b0);
            chk("R4 or set", flag_or, 1);
            chk("R4 data kept", rx_data, a);
            clear_all();
            chk("R4 cleared", {flag_rxf, flag_or}, 0);
        end

        // R5
        send_char(8'h33, 1'b0);
        rd_stat();
        send_char(8'h44, 1'b0);
        rd_data();
        chk("R5 rxf cleared", flag_rxf, 0);
        chk("R5 late or kept", flag_or, 1);
        chk("R5 data", rx_data, 8'h33);
        rd_data();
        chk("R5 empty record", flag_or, 1);
        clear_all();
        chk("R5 or cleared", flag_or, 0);

        // R6
        send_char(8'h55, 1'b1);
        chk("R6 nf set", flag_nf, 1);
        chk("R6 rxf set", flag_rxf, 1);
        clear_all();
        chk("R6 nf cleared", {flag_nf, flag_rxf}, 0);

        // R11
        send_char(8'h66, 1'b0);
        rd_stat();
        data_rd = 1'b1; rx_char_done = 1'b1; rx_char_data = 8'h77;
        step();
        data_rd = 1'b0; rx_char_done = 1'b0;
        chk("R11 rxf stays", flag_rxf, 1);
        chk("R11 data new", rx_data, 8'h77);
        chk("R11 no overrun", flag_or, 0);
        clear_all();

        // R7 sweep
        for (int lf = 0; lf < 2; lf++) begin
            for (int n = 8; n <= 12; n++) begin
                long_frame = lf[0];
                send_char(8'(n), 1'b0);
                clear_all();
                tick(1'b0);
                for (int k = 0; k < n; k++) tick(1'b1);
                chk($sformatf("R7 lf=%0d n=%0d", lf, n), flag_idle, (n >= 10 + lf) ? 1 : 0);
                if (flag_idle) begin
                    clear_all();
                    chk("R7 idle cleared", flag_idle, 0);
                end
            end
        end
        long_frame = 1'b0;
        send_char(8'h01, 1'b0);
        clear_all();
        for (int k = 0; k < 7; k++) tick(1'b1);
        tick(1'b0);
        for (int k = 0; k < 7; k++) tick(1'b1);
        chk("R7 zero restarts", flag_idle, 0);
        for (int k = 0; k < 3; k++) tick(1'b1);
        chk("R7 reaches after restart", flag_idle, 1);

        // R8
        clear_all();
        for (int k = 0; k < 12; k++) tick(1'b1);
        chk("R8 not rearmed", flag_idle, 0);
        send_char(8'h02, 1'b0);
        clear_all();
        rx_en = 1'b0; step(); rx_en = 1'b1; step();
        for (int k = 0; k < 12; k++) tick(1'b1);
        chk("R8 enable disarms", flag_idle, 0);

        // R9
        chk("R9 idle tc", flag_tc, 1);
        tx_load = 1'b1; step(); tx_load = 1'b0;
        chk("R9 drop", flag_tc, 0);
        step(); step();
        chk("R9 latency low", flag_tc, 0);
        tx_busy = 1'b1; step(); step();
        chk("R9 busy low", flag_tc, 0);
        tx_load = 1'b1; step(); tx_load = 1'b0;
        tx_busy = 1'b0; step();
        chk("R9 pending low", flag_tc, 0);
        tx_busy = 1'b1; step(); tx_busy = 1'b0; step();
        chk("R9 back high", flag_tc, 1);

        // R10 sweep
        send_char(8'h0F, 1'b1);
        for (int k = 0; k < 10; k++) tick(1'b1);
        send_char(8'hF0, 1'b0);
        chk("R10 setup", {flag_rxf, flag_idle, flag_or, flag_nf, flag_tc}, 5'b11111);
        for (int e = 0; e < 32; e++) begin
            {ie_rxf, ie_idle, ie_or, ie_nf, ie_tc} = 5'(e);
            #1;
            chk("R10 irq_rx", irq_rx, (e >> 3) != 0 ? 1 : 0);
            chk("R10 irq_err", irq_err, ((e >> 1) & 3) != 0 ? 1 : 0);
            chk("R10 irq_tx", irq_tx, e & 1);
        end
        clear_all();
        chk("R10 gated off", {irq_rx, irq_err, irq_tx}, 3'b001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule